// File: doc/BRIEF.md
# Double-Buffered Crosspoint Switch Controller

This block is a non-blocking crosspoint switch between `N_IN` input lanes and `N_OUT` output lanes. Every output owns a selector that can pick any input, so one input may fan out to any subset of the outputs. Each output can also be turned off on its own; an output that is off drops its enable flag and drives zeros.

A host programs the switch one output at a time through a small control port. A write, accepted only while chip select is high, names an output, the input it should take and whether it is disabled. Writes land in a shadow row of settings. The live routing is held in a separate active row and changes only when an apply strobe copies the whole shadow row across in one clock edge. Outputs whose setting is the same in both rows are left untouched. Two global resets act on both rows at once: a broadcast reset routes every output to input 0 and enables it, and an off reset disables every output. Control logic is synchronous to one clock; the data path from inputs to outputs is combinational.

Top module: `xbar_switch`

## Requirements
- R1: After the synchronous reset `rst` every output is disabled (`dout_en` all 0, `dout` all 0), in both rows, so a following apply keeps them disabled.
- R2: An enabled output `o` carries lane `din[s*LANE_W +: LANE_W]` of its active selected input `s` combinationally, in the same cycle as `din` changes; one input can feed several outputs at once.
- R3: A disabled output drives `dout_en[o]=0` and all-zero data in `dout[o*LANE_W +: LANE_W]`.
- R4: When `cs` and `wr` are both 1 at a clock edge, the shadow entry for output `out_addr` takes input `in_addr` and disable bit `dis` (1 = disabled, 0 = enabled); with `cs` at 0 the write is ignored.
- R5: Writes do not change the outputs; only a `cfg_apply` strobe copies all shadow entries into the active row, visible after that clock edge.
- R6: On an apply, outputs whose shadow and active settings are equal keep their enable and data unchanged.
- R7: A `bcast_rst` strobe sets every entry of both rows to input 0, enabled.
- R8: A `tri_rst` strobe sets every entry of both rows to disabled; if `tri_rst` and `bcast_rst` arrive together, `tri_rst` wins.
- R9: A global reset in the same cycle as a write or an apply wins: the write is dropped and the apply has no effect.
- R10: A write and an apply in the same cycle make the apply copy the shadow row as it stood before that write; the new setting appears only at the next apply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all control state |
| rst | input | 1 | Synchronous active-high reset, disables all outputs |
| cs | input | 1 | Chip select gating writes |
| wr | input | 1 | Single-cycle write strobe |
| in_addr | input | $clog2(N_IN) | Input to select for the addressed output |
| out_addr | input | $clog2(N_OUT) | Output whose shadow entry is written |
| dis | input | 1 | 1 disables the addressed output |
| cfg_apply | input | 1 | Single-cycle strobe copying shadow row to active row |
| bcast_rst | input | 1 | Strobe routing all outputs to input 0, enabled |
| tri_rst | input | 1 | Strobe disabling all outputs |
| din | input | N_IN*LANE_W | Input lanes, input i at bits i*LANE_W |
| dout | output | N_OUT*LANE_W | Output lanes, output o at bits o*LANE_W |
| dout_en | output | N_OUT | Per-output enable, 1 = driving |

## Verification
The functions that can collide in one cycle are a shadow write and an apply, and a global reset against a write, an apply or the other reset. The bench provokes each by raising the strobes on the same clock edge, then judges the outcome at the ports: after a write plus apply the old route must still show and the new one must appear only after a second apply; after a reset plus apply or write the outputs must show the reset state, and a later apply must not revive the dropped write.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
  typedef enum logic [1:0] {
    GR_NONE  = 2'd0,
    GR_BCAST = 2'd1,
    GR_OFF   = 2'd2
  } glob_rst_e;
endpackage

// File: rtl/xbar_ctrl.sv
module xbar_ctrl
  import xbar_pkg::*;
(
  input  logic      rst,
  input  logic      cs,
  input  logic      wr,
  input  logic      cfg_apply,
  input  logic      bcast_rst,
  input  logic      tri_rst,
  output glob_rst_e grst,
  output logic      wr_ok,
  output logic      apply_ok
);
  always_comb begin
    if (rst || tri_rst)  grst = GR_OFF;
    else if (bcast_rst)  grst = GR_BCAST;
    else                 grst = GR_NONE;
    wr_ok    = (grst == GR_NONE) && cs && wr;
    apply_ok = (grst == GR_NONE) && cfg_apply;
  end
endmodule

// File: rtl/xbar_cfg_rows.sv
module xbar_cfg_rows
  import xbar_pkg::*;
#(
  parameter int N_IN  = 8,
  parameter int N_OUT = 8,
  localparam int SW   = (N_IN  > 1) ? $clog2(N_IN)  : 1,
  localparam int OW   = (N_OUT > 1) ? $clog2(N_OUT) : 1
) (
  input  logic                  clk,
  input  glob_rst_e             grst,
  input  logic                  wr_ok,
  input  logic                  apply_ok,
  input  logic [OW-1:0]         w_out,
  input  logic [SW-1:0]         w_sel,
  input  logic                  w_dis,
  output logic [N_OUT*SW-1:0]   act_sel,
  output logic [N_OUT-1:0]      act_dis
);
  logic [SW-1:0] sh_sel [N_OUT];
  logic          sh_dis [N_OUT];
  logic [SW-1:0] ac_sel [N_OUT];
  logic          ac_dis [N_OUT];

  always_ff @(posedge clk) begin
    for (int o = 0; o < N_OUT; o++) begin
      if (grst != GR_NONE) begin
        sh_sel[o] <= '0;
        ac_sel[o] <= '0;
        sh_dis[o] <= (grst == GR_OFF);
        ac_dis[o] <= (grst == GR_OFF);
      end else begin
        if (apply_ok) begin
          ac_sel[o] <= sh_sel[o];
          ac_dis[o] <= sh_dis[o];
        end
        if (wr_ok && (w_out == OW'(o))) begin
          sh_sel[o] <= w_sel;
          sh_dis[o] <= w_dis;
        end
      end
    end
  end

  genvar g;
  generate
    for (g = 0; g < N_OUT; g++) begin : g_flat
      assign act_sel[g*SW +: SW] = ac_sel[g];
      assign act_dis[g]          = ac_dis[g];
    end
  endgenerate
endmodule

// File: rtl/xbar_out_mux.sv
module xbar_out_mux #(
  parameter int N_IN   = 8,
  parameter int LANE_W = 1,
  localparam int SW    = (N_IN > 1) ? $clog2(N_IN) : 1
) (
  input  logic [N_IN*LANE_W-1:0] din,
  input  logic [SW-1:0]          sel,
  input  logic                   off,
  output logic [LANE_W-1:0]      q,
  output logic                   en
);
  always_comb begin
    q = '0;
    for (int i = 0; i < N_IN; i++)
      if (!off && (sel == SW'(i))) q = din[i*LANE_W +: LANE_W];
    en = !off;
  end
endmodule

// File: rtl/xbar_switch.sv
module xbar_switch
  import xbar_pkg::*;
#(
  parameter int N_IN   = 8,
  parameter int N_OUT  = 8,
  parameter int LANE_W = 1,
  localparam int SW    = (N_IN  > 1) ? $clog2(N_IN)  : 1,
  localparam int OW    = (N_OUT > 1) ? $clog2(N_OUT) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cs,
  input  logic                    wr,
  input  logic [SW-1:0]           in_addr,
  input  logic [OW-1:0]           out_addr,
  input  logic                    dis,
  input  logic                    cfg_apply,
  input  logic                    bcast_rst,
  input  logic                    tri_rst,
  input  logic [N_IN*LANE_W-1:0]  din,
  output logic [N_OUT*LANE_W-1:0] dout,
  output logic [N_OUT-1:0]        dout_en
);
  glob_rst_e           grst;
  logic                wr_ok, apply_ok;
  logic [N_OUT*SW-1:0] act_sel;
  logic [N_OUT-1:0]    act_dis;

  xbar_ctrl u_ctrl (
    .rst(rst), .cs(cs), .wr(wr), .cfg_apply(cfg_apply),
    .bcast_rst(bcast_rst), .tri_rst(tri_rst),
    .grst(grst), .wr_ok(wr_ok), .apply_ok(apply_ok)
  );

  xbar_cfg_rows #(.N_IN(N_IN), .N_OUT(N_OUT)) u_rows (
    .clk(clk), .grst(grst), .wr_ok(wr_ok), .apply_ok(apply_ok),
    .w_out(out_addr), .w_sel(in_addr), .w_dis(dis),
    .act_sel(act_sel), .act_dis(act_dis)
  );

  genvar g;
  generate
    for (g = 0; g < N_OUT; g++) begin : g_out
      xbar_out_mux #(.N_IN(N_IN), .LANE_W(LANE_W)) u_mux (
        .din(din), .sel(act_sel[g*SW +: SW]), .off(act_dis[g]),
        .q(dout[g*LANE_W +: LANE_W]), .en(dout_en[g])
      );
    end
  endgenerate
endmodule

// File: rtl/xbar_checker.sv
module xbar_checker #(
  parameter int N_IN   = 8,
  parameter int N_OUT  = 8,
  parameter int LANE_W = 1
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    cfg_apply,
  input logic                    bcast_rst,
  input logic                    tri_rst,
  input logic [N_IN*LANE_W-1:0]  din,
  input logic [N_OUT*LANE_W-1:0] dout,
  input logic [N_OUT-1:0]        dout_en
);
  logic rst_q = 1'b0;
  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst_q && !rst)
      AST_RST_OFF: assert (dout_en == '0 && dout == '0); // R1
  end

  always_comb begin
    for (int o = 0; o < N_OUT; o++)
      if (dout_en[o] === 1'b0)
        AST_DIS_QUIET: assert (dout[o*LANE_W +: LANE_W] == '0); // R3
  end

  AST_HOLD_NO_APPLY: assert property (@(posedge clk) disable iff (rst)
    (!cfg_apply && !bcast_rst && !tri_rst) |=> $stable(dout_en)); // R5

  AST_BCAST_ROUTE: assert property (@(posedge clk) disable iff (rst)
    (bcast_rst && !tri_rst) |=> (dout_en == '1 && dout == {N_OUT{din[LANE_W-1:0]}})); // R7

  AST_TRI_OFF: assert property (@(posedge clk) disable iff (rst)
    tri_rst |=> (dout_en == '0 && dout == '0)); // R8

  AST_RST_BEATS_APPLY: assert property (@(posedge clk) disable iff (rst)
    (tri_rst && cfg_apply) |=> (dout_en == '0)); // R9
endmodule

bind xbar_switch xbar_checker #(.N_IN(N_IN), .N_OUT(N_OUT), .LANE_W(LANE_W)) u_chk (
  .clk(clk), .rst(rst), .cfg_apply(cfg_apply), .bcast_rst(bcast_rst),
  .tri_rst(tri_rst), .din(din), .dout(dout), .dout_en(dout_en)
);

// File: tb/sim_xbar_switch.sv
module sim_xbar_switch;
  localparam int CLK_NS = 10;
  localparam int NI = 8, NO = 8, LW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs = 0, wr = 0, dis = 0, cfg_apply = 0, bcast_rst = 0, tri_rst = 0;
  logic [2:0] in_addr = '0, out_addr = '0;
  logic [NI*LW-1:0] din = '0;
  logic [NO*LW-1:0] dout;
  logic [NO-1:0]    dout_en;

  int total = 0, bad = 0;
  int sh_sel [NO], ac_sel [NO];
  bit sh_dis [NO], ac_dis [NO];

  always #(CLK_NS/2) clk = ~clk;

  xbar_switch #(.N_IN(NI), .N_OUT(NO), .LANE_W(LW)) u0 (
    .clk(clk), .rst(rst), .cs(cs), .wr(wr), .in_addr(in_addr), .out_addr(out_addr),
    .dis(dis), .cfg_apply(cfg_apply), .bcast_rst(bcast_rst), .tri_rst(tri_rst),
    .din(din), .dout(dout), .dout_en(dout_en)
  );

  task automatic set_din(input int base);
    for (int i = 0; i < NI; i++) din[i*LW +: LW] = LW'((i * 3 + base) & 15);
    #1;
  endtask

  task automatic model_all(input bit off);
    for (int o = 0; o < NO; o++) begin
      sh_sel[o] = 0; ac_sel[o] = 0; sh_dis[o] = off; ac_dis[o] = off;
    end
  endtask

  task automatic model_apply();
    for (int o = 0; o < NO; o++) begin ac_sel[o] = sh_sel[o]; ac_dis[o] = sh_dis[o]; end
  endtask

  task automatic check_outs(input string req);
    logic [NO*LW-1:0] ed;
    logic [NO-1:0]    ee;
    ed = '0; ee = '0;
    for (int o = 0; o < NO; o++) begin
      ee[o] = !ac_dis[o];
      if (!ac_dis[o]) ed[o*LW +: LW] = din[ac_sel[o]*LW +: LW];
    end
    total++;
    if (dout !== ed || dout_en !== ee) begin
      bad++;
      $display("FAIL %s: dout=%h en=%b expected dout=%h en=%b", req, dout, dout_en, ed, ee);
    end
  endtask

  // Drives strobes for one clock edge; returns after the following negedge.
  task automatic strobe(input bit w, input bit c, input int o, input int i, input bit d,
                        input bit ap, input bit br, input bit tr);
    @(negedge clk);
    wr = w; cs = c; out_addr = 3'(o); in_addr = 3'(i); dis = d;
    cfg_apply = ap; bcast_rst = br; tri_rst = tr;
    @(negedge clk);
    wr = 0; cs = 0; cfg_apply = 0; bcast_rst = 0; tri_rst = 0;
    #1;
  endtask

  task automatic write(input int o, input int i, input bit d);
    strobe(1, 1, o, i, d, 0, 0, 0);
    sh_sel[o] = i; sh_dis[o] = d;
  endtask

  task automatic apply();
    strobe(0, 0, 0, 0, 0, 1, 0, 0);
    model_apply();
  endtask

  task automatic t_reset();
    set_din(1);
    model_all(1);
    check_outs("R1 reset disables all");
    apply();
    check_outs("R1 apply after reset stays off / R3");
  endtask

  task automatic t_bcast();
    strobe(0, 0, 0, 0, 0, 0, 1, 0);
    model_all(0);
    check_outs("R7 broadcast to input0");
    set_din(5);
    check_outs("R2 fan-out of input0 follows din");
  endtask

  task automatic t_shadow();
    write(3, 5, 0);
    write(0, 7, 0);
    write(6, 5, 0);
    check_outs("R5 writes invisible before apply");
    apply();
    check_outs("R5 apply copies row");
    set_din(9);
    check_outs("R2 routes follow new din");
  endtask

  task automatic t_cs();
    strobe(1, 0, 3, 1, 1, 0, 0, 0);
    apply();
    check_outs("R4 write without cs ignored");
  endtask

  task automatic t_disable();
    write(5, 2, 1);
    apply();
    check_outs("R3 disabled output quiet");
    write(5, 4, 0);
    apply();
    check_outs("R4 re-enable with new input");
  endtask

  task automatic t_undisturbed();
    logic [NO*LW-1:0] d0;
    logic [NO-1:0]    e0;
    d0 = dout; e0 = dout_en;
    apply();
    total++;
    if (dout !== d0 || dout_en !== e0) begin
      bad++;
      $display("FAIL R6 unchanged apply: dout=%h en=%b expected dout=%h en=%b", dout, dout_en, d0, e0);
    end
    write(1, 6, 0);
    apply();
    check_outs("R6 only output1 changes");
  endtask

  task automatic t_same_cycle();
    strobe(1, 1, 2, 6, 0, 1, 0, 0);
    model_apply();
    sh_sel[2] = 6; sh_dis[2] = 0;
    check_outs("R10 apply takes pre-write shadow");
    apply();
    check_outs("R10 write visible at next apply");
  endtask

  task automatic t_tri();
    strobe(0, 0, 0, 0, 0, 0, 0, 1);
    model_all(1);
    check_outs("R8 off reset");
    apply();
    check_outs("R8 shadow also cleared");
  endtask

  task automatic t_collide();
    strobe(0, 0, 0, 0, 0, 0, 1, 0);
    model_all(0);
    write(4, 2, 0);
    strobe(0, 0, 0, 0, 0, 1, 0, 1);
    model_all(1);
    check_outs("R9 off reset beats apply");
    apply();
    check_outs("R9 stale write not revived");
    strobe(0, 0, 0, 0, 0, 0, 1, 1);
    model_all(1);
    check_outs("R8 off beats broadcast");
    strobe(1, 1, 7, 3, 0, 0, 1, 0);
    model_all(0);
    apply();
    check_outs("R9 broadcast drops same-cycle write");
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    set_din(0);
    repeat (3) @(negedge clk);
    rst = 0;
    #1;
    t_reset();
    t_bcast();
    t_shadow();
    t_cs();
    t_disable();
    t_undisturbed();
    t_same_cycle();
    t_tri();
    t_collide();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule